// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches a stream of received Ethernet frame bytes and raises a one-cycle wake indication when a frame carries a magic-packet pattern. A qualifying frame has a payload with a run of `0xFF` synchronization bytes followed immediately by sixteen back-to-back copies of the programmed 48-bit station address. The frame must also pass a destination-address check and end with a good-frame indication. The destination check is strict by default: the destination must equal the station address. Either of two OR'ed acceptance enables relaxes it so that any unicast, multicast or broadcast destination is taken.

Detection is active only while wake mode is armed. Wake mode is armed by a software enable, or by a pin enable together with a low power-good input. Frame reception, FCS checking and register storage belong to neighbouring blocks. This block only consumes the byte stream, its frame delimiters, the station address and the mode controls.

The stream uses four strobes:
- `rx_valid` qualifies `rx_data`.
- `rx_sof` marks the first byte of a frame.
- `rx_eof` marks a separate end-of-frame cycle; any byte presented in that cycle is ignored.
- `rx_good` is sampled in the end-of-frame cycle.

Top module: `magic_wake_detect`

## Requirements
- R1: A match requires a run of at least six `0xFF` bytes followed directly by sixteen consecutive copies of `station_addr`. Each copy is sent with `station_addr[47:40]` first and `station_addr[7:0]` last. The search covers only the bytes after the first six (destination) bytes of the frame.
- R2: With both `accept_any_a` and `accept_any_b` low, a frame qualifies only if its first six bytes equal `station_addr` in that same byte order.
- R3: With either `accept_any_a` or `accept_any_b` high, the destination bytes may hold any value (unicast, multicast or broadcast).
- R4: The acceptance enables change only the destination check. A frame with a defective synchronization or repetition pattern is rejected whatever their values.
- R5: Wake mode is armed when `sw_enable` is 1, or when `pin_enable` is 1 and `power_good` is 0. A match is reported only if wake mode is armed in the end-of-frame cycle.
- R6: `match_pulse` is high for exactly one cycle, the cycle after an `rx_eof` cycle with `rx_good` high. A frame ended with `rx_good` low gives no pulse.
- R7: A byte that differs from the expected synchronization or address byte restarts the search. With no complete pattern after it, the frame gives no match.
- R8: A restarting byte that equals `0xFF` counts as the first byte of a new synchronization run. A synchronization run longer than six bytes is accepted.
- R9: `rx_sof` clears all search and destination progress. A pattern split across two frames never matches.
- R10: After reset `match_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte strobe for `rx_data` |
| rx_data | input | 8 | Received frame byte |
| rx_sof | input | 1 | First byte of a frame (with `rx_valid`) |
| rx_eof | input | 1 | End-of-frame cycle; data ignored |
| rx_good | input | 1 | Frame good, sampled with `rx_eof` |
| station_addr | input | 48 | Programmed station address, bits 47:40 sent first |
| accept_any_a | input | 1 | Destination relaxation enable A |
| accept_any_b | input | 1 | Destination relaxation enable B |
| sw_enable | input | 1 | Software wake-mode enable |
| pin_enable | input | 1 | Pin-controlled wake-mode enable |
| power_good | input | 1 | Power-good input; low arms wake mode when `pin_enable` is set |
| match_pulse | output | 1 | One-cycle magic-packet match indication |

## Verification
The bench builds the block with its default parameters: a six-byte address, a six-byte synchronization run and sixteen repetitions. At these values a full magic region is only 102 bytes, so every byte position in it can be corrupted in turn, with the acceptance enables alternated across the sweep. The small control space is also swept exhaustively:
- all four enable combinations against four destination classes;
- all eight combinations of the three mode inputs.

Directed frames cover the remaining boundaries:
- fifteen versus sixteen copies;
- an over-long synchronization run;
- a restart on an `0xFF` byte compared with a restart on a non-`0xFF` byte;
- a pattern split by a new start of frame.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
   localparam int unsigned OCTET_W = 8;
   typedef logic [OCTET_W-1:0] octet_t;
   localparam octet_t SYNC_OCTET = 8'hFF;
endpackage

// File: rtl/mwd_arm.sv
module mwd_arm #(
   parameter bit PG_ACTIVE_LOW = 1'b1
) (
   input  logic sw_enable,
   input  logic pin_enable,
   input  logic power_good,
   output logic armed
);
   logic pg_lost;

   generate
      if (PG_ACTIVE_LOW) begin : g_pg_low
         assign pg_lost = ~power_good;
      end else begin : g_pg_high
         assign pg_lost = power_good;
      end
   endgenerate

   assign armed = sw_enable | (pin_enable & pg_lost);
endmodule

// File: rtl/mwd_dest_filter.sv
module mwd_dest_filter
   import mwd_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned IDX_W      = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        byte_en,
   input  logic                        in_hdr,
   input  logic [IDX_W-1:0]            idx,
   input  octet_t                      data,
   input  logic [ADDR_BYTES*OCTET_W-1:0] station_addr,
   input  logic                        relax_a,
   input  logic                        relax_b,
   output logic                        dest_ok
);
   localparam int unsigned COL_W = $clog2(ADDR_BYTES);

   octet_t sta [ADDR_BYTES];
   logic   dest_eq;

   generate
      for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_sta
         assign sta[k] = station_addr[OCTET_W*(ADDR_BYTES-1-k) +: OCTET_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dest_eq <= 1'b0;
      end else if (byte_en && in_hdr) begin
         dest_eq <= (data == sta[idx[COL_W-1:0]]) && ((idx == '0) || dest_eq);
      end
   end

   assign dest_ok = relax_a | relax_b | dest_eq;
endmodule

// File: rtl/mwd_pattern_scan.sv
module mwd_pattern_scan
   import mwd_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned SYNC_LEN   = 6,
   parameter int unsigned REPEAT_CNT = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          byte_en,
   input  logic                          scan_en,
   input  logic                          restart,
   input  logic                          flush,
   input  octet_t                        data,
   input  logic [ADDR_BYTES*OCTET_W-1:0] station_addr,
   output logic                          found
);
   localparam int unsigned SYNC_W = $clog2(SYNC_LEN + 1);
   localparam int unsigned COL_W  = $clog2(ADDR_BYTES);
   localparam int unsigned REP_W  = $clog2(REPEAT_CNT + 1);
   localparam logic [SYNC_W-1:0] SYNC_FULL = SYNC_W'(SYNC_LEN);
   localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(ADDR_BYTES - 1);
   localparam logic [REP_W-1:0]  REP_LAST  = REP_W'(REPEAT_CNT - 1);

   octet_t            sta [ADDR_BYTES];
   logic [SYNC_W-1:0] sync_q, sync_d;
   logic [COL_W-1:0]  col_q, col_d;
   logic [REP_W-1:0]  rep_q, rep_d;
   logic              found_d;
   logic              in_reps;

   generate
      for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_sta
         assign sta[k] = station_addr[OCTET_W*(ADDR_BYTES-1-k) +: OCTET_W];
      end
   endgenerate

   assign in_reps = (sync_q == SYNC_FULL);

   always_comb begin
      sync_d  = sync_q;
      col_d   = col_q;
      rep_d   = rep_q;
      found_d = found;
      if (restart || flush) begin
         sync_d  = '0;
         col_d   = '0;
         rep_d   = '0;
         found_d = 1'b0;
      end else if (byte_en && scan_en && !found) begin
         if (!in_reps) begin
            sync_d = (data == SYNC_OCTET) ? sync_q + SYNC_W'(1) : '0;
         end else if (data == sta[col_q]) begin
            if (col_q == COL_LAST) begin
               col_d = '0;
               if (rep_q == REP_LAST) found_d = 1'b1;
               else                   rep_d = rep_q + REP_W'(1);
            end else begin
               col_d = col_q + COL_W'(1);
            end
         end else begin
            col_d = '0;
            rep_d = '0;
            if (data != SYNC_OCTET)                sync_d = '0;
            else if (col_q == '0 && rep_q == '0)   sync_d = SYNC_FULL;
            else                                   sync_d = SYNC_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         col_q  <= '0;
         rep_q  <= '0;
         found  <= 1'b0;
      end else begin
         sync_q <= sync_d;
         col_q  <= col_d;
         rep_q  <= rep_d;
         found  <= found_d;
      end
   end

   // R1
   reps_need_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_q != '0 || col_q != '0) |-> in_reps);

   // R1
   found_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(found) |-> $past(byte_en && scan_en));

   // R9
   restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!found && rep_q == '0 && col_q == '0));
endmodule

// File: rtl/magic_wake_detect.sv
module magic_wake_detect
   import mwd_pkg::*;
#(
   parameter int unsigned ADDR_BYTES    = 6,
   parameter int unsigned SYNC_LEN      = 6,
   parameter int unsigned REPEAT_CNT    = 16,
   parameter bit          PG_ACTIVE_LOW = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rx_valid,
   input  logic [7:0]                    rx_data,
   input  logic                          rx_sof,
   input  logic                          rx_eof,
   input  logic                          rx_good,
   input  logic [ADDR_BYTES*OCTET_W-1:0] station_addr,
   input  logic                          accept_any_a,
   input  logic                          accept_any_b,
   input  logic                          sw_enable,
   input  logic                          pin_enable,
   input  logic                          power_good,
   output logic                          match_pulse
);
   localparam int unsigned HDR_W = $clog2(ADDR_BYTES + 1);
   localparam logic [HDR_W-1:0] HDR_END = HDR_W'(ADDR_BYTES);

   generate
      if (ADDR_BYTES < 2) begin : g_bad_addr
         $error("ADDR_BYTES must be at least 2");
      end
      if (SYNC_LEN < 1) begin : g_bad_sync
         $error("SYNC_LEN must be at least 1");
      end
      if (REPEAT_CNT < 1) begin : g_bad_rep
         $error("REPEAT_CNT must be at least 1");
      end
   endgenerate

   logic             byte_en, restart;
   logic [HDR_W-1:0] hdr_q, eff_idx;
   logic             in_hdr, scan_en;
   logic             armed, dest_ok, found;

   assign byte_en = rx_valid & ~rx_eof;
   assign restart = byte_en & rx_sof;
   assign eff_idx = rx_sof ? '0 : hdr_q;
   assign in_hdr  = (eff_idx < HDR_END);
   assign scan_en = ~in_hdr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 hdr_q <= HDR_END;
      else if (byte_en && in_hdr) hdr_q <= eff_idx + HDR_W'(1);
   end

   mwd_arm #(.PG_ACTIVE_LOW(PG_ACTIVE_LOW)) u_arm (
      .sw_enable (sw_enable),
      .pin_enable(pin_enable),
      .power_good(power_good),
      .armed     (armed)
   );

   mwd_dest_filter #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(HDR_W)) u_dest (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_en     (byte_en),
      .in_hdr      (in_hdr),
      .idx         (eff_idx),
      .data        (rx_data),
      .station_addr(station_addr),
      .relax_a     (accept_any_a),
      .relax_b     (accept_any_b),
      .dest_ok     (dest_ok)
   );

   mwd_pattern_scan #(
      .ADDR_BYTES(ADDR_BYTES), .SYNC_LEN(SYNC_LEN), .REPEAT_CNT(REPEAT_CNT)
   ) u_scan (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_en     (byte_en),
      .scan_en     (scan_en),
      .restart     (restart),
      .flush       (rx_eof),
      .data        (rx_data),
      .station_addr(station_addr),
      .found       (found)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_pulse <= 1'b0;
      else        match_pulse <= rx_eof & rx_good & armed & dest_ok & found;
   end

   // R6
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |=> !match_pulse);

   // R5
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> $past(rx_eof && rx_good && armed));
endmodule

// File: tb/tb_magic_wake_detect.sv
`timescale 1ns/1ps
module tb_magic_wake_detect;
   localparam logic [47:0] STA = 48'h02_1A_2B_3C_4D_5E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic [47:0] station_addr = STA;
   logic        accept_any_a = 1'b0, accept_any_b = 1'b0;
   logic        sw_enable = 1'b1, pin_enable = 1'b0, power_good = 1'b1;
   logic        match_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [7:0] fq[$];

   always #4 clk = ~clk;

   magic_wake_detect dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_good(rx_good),
      .station_addr(station_addr), .accept_any_a(accept_any_a),
      .accept_any_b(accept_any_b), .sw_enable(sw_enable),
      .pin_enable(pin_enable), .power_good(power_good),
      .match_pulse(match_pulse)
   );

   task automatic check(input logic got, input logic exp, input string req, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
      end
   endtask

   function automatic logic [7:0] sta_byte(input int i);
      return STA[8*(5-i) +: 8];
   endfunction

   task automatic push_hdr(input logic [47:0] dst);
      for (int i = 0; i < 6; i++) fq.push_back(dst[8*(5-i) +: 8]);
      for (int i = 0; i < 6; i++) fq.push_back(8'h10 + 8'(i));
      fq.push_back(8'h08);
      fq.push_back(8'h42);
   endtask

   task automatic push_sync(input int n);
      for (int i = 0; i < n; i++) fq.push_back(8'hFF);
   endtask

   task automatic push_reps(input int n);
      for (int r = 0; r < n; r++)
         for (int i = 0; i < 6; i++) fq.push_back(sta_byte(i));
   endtask

   task automatic send_bytes();
      for (int i = 0; i < fq.size(); i++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_sof   = (i == 0);
         rx_data  = fq[i];
      end
      fq.delete();
   endtask

   task automatic expect_frame(input bit good, input logic exp, input string req, input string what);
      logic got, after;
      send_bytes();
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b1; rx_good = good;
      rx_data  = 8'hFF;
      @(negedge clk);
      rx_eof = 1'b0; rx_good = 1'b0;
      got = match_pulse;
      @(negedge clk);
      after = match_pulse;
      check(got, exp, req, what);
      check(after, 1'b0, "R6", {what, " pulse width"});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [47:0] dests [4];
      dests[0] = STA;
      dests[1] = 48'h01_00_5E_00_00_07;
      dests[2] = 48'hFF_FF_FF_FF_FF_FF;
      dests[3] = 48'h02_1A_2B_3C_4D_5F;

      repeat (3) @(negedge clk);
      check(match_pulse, 1'b0, "R10", "reset state");
      rst_n = 1'b1;
      @(negedge clk);
      check(match_pulse, 1'b0, "R10", "after reset release");

      // R2, R3: destination classes against every enable combination
      for (int d = 0; d < 4; d++)
         for (int e = 0; e < 4; e++) begin
            accept_any_a = e[0];
            accept_any_b = e[1];
            push_hdr(dests[d]); push_sync(6); push_reps(16);
            expect_frame(1'b1, (d == 0) || (e != 0), (e == 0) ? "R2" : "R3", "destination sweep");
         end
      accept_any_a = 1'b0; accept_any_b = 1'b0;

      // R5: all mode input combinations
      for (int m = 0; m < 8; m++) begin
         sw_enable = m[0]; pin_enable = m[1]; power_good = m[2];
         push_hdr(STA); push_sync(6); push_reps(16);
         expect_frame(1'b1, m[0] | (m[1] & ~m[2]), "R5", "mode sweep");
      end
      sw_enable = 1'b1; pin_enable = 1'b0; power_good = 1'b1;

      // R6: bad frame gives no pulse
      push_hdr(STA); push_sync(6); push_reps(16);
      expect_frame(1'b0, 1'b0, "R6", "frame not good");

      // R7, R4: corrupt each byte of the magic region in turn
      for (int k = 0; k < 6 + 96; k++) begin
         accept_any_a = k[0];
         push_hdr(STA);
         for (int j = 0; j < 6 + 96; j++) begin
            logic [7:0] b;
            b = (j < 6) ? 8'hFF : sta_byte((j - 6) % 6);
            if (j == k) b = b ^ 8'h01;
            fq.push_back(b);
         end
         fq.push_back(8'h00);
         expect_frame(1'b1, 1'b0, k[0] ? "R4" : "R7", "corruption sweep");
      end
      accept_any_a = 1'b0;

      // R1: repetition count boundary and trailing pad
      push_hdr(STA); push_sync(6); push_reps(15);
      expect_frame(1'b1, 1'b0, "R1", "fifteen copies");
      push_hdr(STA); push_sync(6); push_reps(16); fq.push_back(8'h00); fq.push_back(8'h11);
      expect_frame(1'b1, 1'b1, "R1", "sixteen copies with pad");
      push_hdr(STA); push_sync(5); push_reps(16);
      expect_frame(1'b1, 1'b0, "R1", "five sync bytes");

      // R8: long sync run and 0xFF restart byte
      push_hdr(STA); push_sync(9); push_reps(16);
      expect_frame(1'b1, 1'b1, "R8", "nine sync bytes");
      push_hdr(STA); push_sync(6); push_reps(3); push_sync(1); push_sync(5); push_reps(16);
      expect_frame(1'b1, 1'b1, "R8", "FF restart byte starts run");
      push_hdr(STA); push_sync(6); push_reps(3); fq.push_back(8'h00); push_sync(5); push_reps(16);
      expect_frame(1'b1, 1'b0, "R7", "non-FF restart then short run");

      // R9: pattern split across a new start of frame
      push_hdr(STA); push_sync(6); push_reps(8);
      send_bytes();
      push_hdr(STA); push_reps(8);
      expect_frame(1'b1, 1'b0, "R9", "split across sof");
      push_hdr(STA); push_sync(6); push_reps(16);
      expect_frame(1'b1, 1'b1, "R9", "clean frame after split");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule